// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home node of a three-node distributed shared memory kept coherent with a write-invalidate scheme. Each memory block it owns has a directory entry: a state (Uncached, Shared or Exclusive) and a vector with one bit per node. The vector holds the sharer set, or the single owner when the block is Exclusive. A small word memory holds the home copy of each block.

A node that misses sends a read miss or a write miss. When the block is held Exclusive by another node, the controller sends that owner a fetch, or a fetch with invalidate. It then waits for the owner's write-back, stores the returned word, and replies to the requester. A write miss to a Shared block first sends one invalidate to each other sharer. Only after that does the requester get its data reply. The controller handles one transaction at a time and holds `busy` high while a transaction spans more than one step. Outgoing messages carry either one address or one data word. Messages addressed to the home node itself are flagged local, because they never travel on the interconnect.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset `busy` and `msg_valid` are low, every directory entry is Uncached and every memory word is zero. A first miss to any block is answered with a data reply carrying zero, with no fetch before it.
- R2: A read miss to an Uncached or Shared block produces one data reply (kind code 5) to the requester in the cycle after acceptance, and adds the requester to the sharer set.
- R3: A write miss to an Uncached block produces one data reply to the requester in the cycle after acceptance. The requester becomes the sole Exclusive owner.
- R4: A write miss to a block held Exclusive by another node first sends a fetch-invalidate (kind code 3) to the owner. The data reply goes to the requester in the second cycle after the matching write-back is presented. The requester becomes the sole owner.
- R5: A read miss to a block held Exclusive by another node first sends a fetch (kind code 2) to the owner, then waits for its write-back, then replies. The block becomes Shared by both the old owner and the requester.
- R6: A write miss to a Shared block sends an invalidate (kind code 4) to every sharer other than the requester. They go out one per cycle, in ascending node number, and the data reply follows in the next cycle. Only the requester remains, as Exclusive owner.
- R7: `msg_local` is high exactly when a message's destination is the home node (node 0).
- R8: Fetch, fetch-invalidate and invalidate messages carry the block address, zero-extended, with `msg_has_data` low. A data reply carries the block's memory word with `msg_has_data` high. A write-back's data word replaces the memory word.
- R9: At most one message leaves per cycle. `busy` is high from the cycle after a multi-step request is accepted until the cycle its data reply appears. Requests presented while `busy` is high are dropped.
- R10: While waiting for a write-back, a write-back whose source is not the owner, or whose address is not the pending block, is ignored.
- R11: A miss from the node that already holds the block Exclusive is answered with a data reply at once, with no fetch. A read miss leaves that node as the only sharer in Shared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | 2 | Requesting node |
| req_addr | input | 2 | Block address |
| busy | output | 1 | Transaction in progress; requests dropped |
| wb_valid | input | 1 | Write-back message present |
| wb_src | input | 2 | Node sending the write-back |
| wb_addr | input | 2 | Block address of the write-back |
| wb_data | input | 32 | Data word of the write-back |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 3 | 2 fetch, 3 fetch-invalidate, 4 invalidate, 5 data reply |
| msg_dst | output | 2 | Destination node |
| msg_payload | output | 32 | Address or data word |
| msg_has_data | output | 1 | Payload is a data word |
| msg_local | output | 1 | Destination is the home node |

## Verification
A one-step miss produces its data reply in the cycle after the accepting edge. Invalidates go out one per cycle from that same cycle, and the reply follows the last one. A fetch also appears one cycle after acceptance. A write-back presented in the fetch's cycle is taken at the next edge, and the reply comes one cycle after that. The bench drives on falling edges and samples on the next falling edge. It counts cycles from acceptance and checks the reply's arrival cycle against the count it expects from the directory state. Quiet windows after ignored write-backs and dropped requests confirm that nothing appears early or extra.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        DIR_UNCACHED = 2'd0,
        DIR_SHARED   = 2'd1,
        DIR_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        MSG_NONE      = 3'd0,
        MSG_FETCH     = 3'd2,
        MSG_FETCH_INV = 3'd3,
        MSG_INVAL     = 3'd4,
        MSG_REPLY     = 3'd5
    } msg_kind_e;

    typedef enum logic [1:0] {
        CT_IDLE    = 2'd0,
        CT_INVAL   = 2'd1,
        CT_WAIT_WB = 2'd2,
        CT_REPLY   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
    parameter int W = 3,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     mask,
    output logic [W-1:0]     onehot,
    output logic [IDX_W-1:0] idx
);

    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign onehot[g]  = mask[g] & ~seen[g];
        assign seen[g+1]  = seen[g] | mask[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dir_entry_table.sv
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int NUM_NODES  = 3,
    localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    output dir_state_e           rd_state,
    output logic [NUM_NODES-1:0] rd_sharers,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  dir_state_e           wr_state,
    input  logic [NUM_NODES-1:0] wr_sharers
);

    dir_state_e           st_d [NUM_BLOCKS];
    dir_state_e           st_q [NUM_BLOCKS];
    logic [NUM_NODES-1:0] sh_d [NUM_BLOCKS];
    logic [NUM_NODES-1:0] sh_q [NUM_BLOCKS];

    always_comb begin
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            st_d[b] = st_q[b];
            sh_d[b] = sh_q[b];
            if (wr_en && wr_addr == ADDR_W'(b)) begin
                st_d[b] = wr_state;
                sh_d[b] = wr_sharers;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (!rst_n) begin
                st_q[b] <= DIR_UNCACHED;
                sh_q[b] <= '0;
            end else begin
                st_q[b] <= st_d[b];
                sh_q[b] <= sh_d[b];
            end
        end
    end

    assign rd_state   = st_q[rd_addr];
    assign rd_sharers = sh_q[rd_addr];

endmodule

// File: rtl/dir_word_mem.sv
module dir_word_mem #(
    parameter int NUM_BLOCKS = 4,
    parameter int DATA_W     = 32,
    localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_d [NUM_BLOCKS];
    logic [DATA_W-1:0] word_q [NUM_BLOCKS];

    always_comb begin
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            word_d[b] = word_q[b];
            if (wr_en && wr_addr == ADDR_W'(b)) word_d[b] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (!rst_n) word_q[b] <= '0;
            else        word_q[b] <= word_d[b];
        end
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NUM_NODES  = 3,
    parameter int NUM_BLOCKS = 4,
    parameter int DATA_W     = 32,
    parameter int HOME_ID    = 0,
    localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
    localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NODE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    input  logic              wb_valid,
    input  logic [NODE_W-1:0] wb_src,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic              msg_valid,
    output logic [2:0]        msg_kind,
    output logic [NODE_W-1:0] msg_dst,
    output logic [DATA_W-1:0] msg_payload,
    output logic              msg_has_data,
    output logic              msg_local
);

    localparam logic [NODE_W:0]   NODE_LIMIT = (NODE_W+1)'(NUM_NODES);
    localparam logic [NODE_W-1:0] HOME_NODE  = NODE_W'(HOME_ID);

    typedef struct packed {
        ctl_state_e           st;
        logic [ADDR_W-1:0]    addr;
        logic [NODE_W-1:0]    src;
        logic                 wr;
        logic [NUM_NODES-1:0] pend;
        logic [NODE_W-1:0]    owner;
        logic                 mv;
        msg_kind_e            mk;
        logic [NODE_W-1:0]    md;
        logic [DATA_W-1:0]    mp;
        logic                 mh;
        logic                 ml;
    } ctl_t;

    ctl_t cd, cq;

    // directory and memory ports
    logic [ADDR_W-1:0]    look_addr;
    dir_state_e           ent_st;
    logic [NUM_NODES-1:0] ent_sh;
    logic                 dir_we;
    dir_state_e           dir_wst;
    logic [NUM_NODES-1:0] dir_wsh;
    logic [DATA_W-1:0]    mem_rd;
    logic                 mem_we;

    // pickers
    logic [NUM_NODES-1:0] owner_oh;
    logic [NODE_W-1:0]    owner_idx;
    logic [NUM_NODES-1:0] pick_in;
    logic [NUM_NODES-1:0] pick_oh;
    logic [NODE_W-1:0]    pick_idx;

    logic [NUM_NODES-1:0] req_bit;
    logic [NUM_NODES-1:0] idle_mask;
    logic                 accept;
    logic                 wb_hit;

    assign look_addr = (cq.st == CT_IDLE) ? req_addr : cq.addr;
    assign req_bit   = NUM_NODES'(1) << req_src;
    assign idle_mask = ent_sh & ~req_bit;
    assign pick_in   = (cq.st == CT_IDLE) ? idle_mask : cq.pend;
    assign accept    = (cq.st == CT_IDLE) && req_valid && ({1'b0, req_src} < NODE_LIMIT);
    assign wb_hit    = (cq.st == CT_WAIT_WB) && wb_valid &&
                       (wb_src == cq.owner) && (wb_addr == cq.addr);

    dir_entry_table #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .NUM_NODES  (NUM_NODES)
    ) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (look_addr),
        .rd_state   (ent_st),
        .rd_sharers (ent_sh),
        .wr_en      (dir_we),
        .wr_addr    (look_addr),
        .wr_state   (dir_wst),
        .wr_sharers (dir_wsh)
    );

    dir_word_mem #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .DATA_W     (DATA_W)
    ) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (look_addr),
        .rd_data (mem_rd),
        .wr_en   (mem_we),
        .wr_addr (cq.addr),
        .wr_data (wb_data)
    );

    dir_low_pick #(.W(NUM_NODES)) owner_pick_i (
        .mask   (ent_sh),
        .onehot (owner_oh),
        .idx    (owner_idx)
    );

    dir_low_pick #(.W(NUM_NODES)) inval_pick_i (
        .mask   (pick_in),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    // next-state logic
    logic                 emit;
    msg_kind_e            e_kind;
    logic [NODE_W-1:0]    e_dst;
    logic [DATA_W-1:0]    e_pay;
    logic                 e_hasd;
    logic                 do_reply;
    logic [NODE_W-1:0]    rep_src;
    logic                 rep_wr;
    logic [NUM_NODES-1:0] rep_bit;
    logic [NUM_NODES-1:0] rest;

    always_comb begin
        cd       = cq;
        emit     = 1'b0;
        e_kind   = MSG_NONE;
        e_dst    = '0;
        e_pay    = '0;
        e_hasd   = 1'b0;
        dir_we   = 1'b0;
        dir_wst  = DIR_UNCACHED;
        dir_wsh  = '0;
        mem_we   = 1'b0;
        do_reply = 1'b0;
        rep_src  = cq.src;
        rep_wr   = cq.wr;
        rep_bit  = '0;
        rest     = pick_in & ~pick_oh;

        unique case (cq.st)
            CT_IDLE: begin
                if (accept) begin
                    cd.addr  = req_addr;
                    cd.src   = req_src;
                    cd.wr    = req_write;
                    cd.owner = owner_idx;
                    if (ent_st == DIR_EXCL && (owner_oh & req_bit) == '0) begin
                        emit   = 1'b1;
                        e_kind = req_write ? MSG_FETCH_INV : MSG_FETCH;
                        e_dst  = owner_idx;
                        e_pay  = DATA_W'(req_addr);
                        cd.st  = CT_WAIT_WB;
                    end else if (req_write && ent_st == DIR_SHARED && |idle_mask) begin
                        emit    = 1'b1;
                        e_kind  = MSG_INVAL;
                        e_dst   = pick_idx;
                        e_pay   = DATA_W'(req_addr);
                        cd.pend = rest;
                        cd.st   = (|rest) ? CT_INVAL : CT_REPLY;
                    end else begin
                        do_reply = 1'b1;
                        rep_src  = req_src;
                        rep_wr   = req_write;
                    end
                end
            end
            CT_INVAL: begin
                emit    = 1'b1;
                e_kind  = MSG_INVAL;
                e_dst   = pick_idx;
                e_pay   = DATA_W'(cq.addr);
                cd.pend = rest;
                cd.st   = (|rest) ? CT_INVAL : CT_REPLY;
            end
            CT_WAIT_WB: begin
                if (wb_hit) begin
                    mem_we = 1'b1;
                    cd.st  = CT_REPLY;
                end
            end
            CT_REPLY: begin
                do_reply = 1'b1;
                cd.st    = CT_IDLE;
            end
            default: cd.st = CT_IDLE;
        endcase

        if (do_reply) begin
            rep_bit = NUM_NODES'(1) << rep_src;
            emit    = 1'b1;
            e_kind  = MSG_REPLY;
            e_dst   = rep_src;
            e_pay   = mem_rd;
            e_hasd  = 1'b1;
            dir_we  = 1'b1;
            dir_wst = rep_wr ? DIR_EXCL : DIR_SHARED;
            dir_wsh = rep_wr ? rep_bit : (ent_sh | rep_bit);
        end

        cd.mv = emit;
        cd.mk = e_kind;
        cd.md = e_dst;
        cd.mp = e_pay;
        cd.mh = e_hasd;
        cd.ml = emit && (e_dst == HOME_NODE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    assign busy         = (cq.st != CT_IDLE);
    assign msg_valid    = cq.mv;
    assign msg_kind     = cq.mk;
    assign msg_dst      = cq.md;
    assign msg_payload  = cq.mp;
    assign msg_has_data = cq.mh;
    assign msg_local    = cq.ml;

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk
    import dir_pkg::*;
#(
    parameter int NUM_NODES = 3,
    parameter int HOME_ID   = 0,
    localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              msg_valid,
    input logic [2:0]        msg_kind,
    input logic [NODE_W-1:0] msg_dst,
    input logic              msg_has_data,
    input logic              msg_local
);

    // R9
    reply_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_REPLY) |-> !busy);

    // R9
    busy_rise_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (msg_valid && msg_kind != MSG_REPLY));

    // R4
    fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == MSG_FETCH || msg_kind == MSG_FETCH_INV)) |=> !msg_valid);

    // R6
    inval_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INVAL) |=>
            (msg_valid && (msg_kind == MSG_INVAL || msg_kind == MSG_REPLY)));

    // R8
    payload_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_has_data == (msg_kind == MSG_REPLY)));

    // R7
    home_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_local) |-> (msg_dst == NODE_W'(HOME_ID)));

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
    .NUM_NODES (NUM_NODES),
    .HOME_ID   (HOME_ID)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .msg_valid    (msg_valid),
    .msg_kind     (msg_kind),
    .msg_dst      (msg_dst),
    .msg_has_data (msg_has_data),
    .msg_local    (msg_local)
);

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_src = '0;
    logic [1:0]  req_addr = '0;
    logic        busy;
    logic        wb_valid = 1'b0;
    logic [1:0]  wb_src = '0;
    logic [1:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic        msg_valid;
    logic [2:0]  msg_kind;
    logic [1:0]  msg_dst;
    logic [31:0] msg_payload;
    logic        msg_has_data;
    logic        msg_local;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dir_home_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_src      (req_src),
        .req_addr     (req_addr),
        .busy         (busy),
        .wb_valid     (wb_valid),
        .wb_src       (wb_src),
        .wb_addr      (wb_addr),
        .wb_data      (wb_data),
        .msg_valid    (msg_valid),
        .msg_kind     (msg_kind),
        .msg_dst      (msg_dst),
        .msg_payload  (msg_payload),
        .msg_has_data (msg_has_data),
        .msg_local    (msg_local)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  src;
        logic [1:0]  addr;
        logic [2:0]  pre_kind;
        logic [1:0]  pre_dst;
        logic [31:0] wb_word;
        logic [2:0]  inv_mask;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 2'd1, 3'd0, 2'd0, 32'h0,  3'b000, 32'h0},
        '{1'b1, 2'd1, 2'd1, 3'd3, 2'd0, 32'h11, 3'b000, 32'h11},
        '{1'b0, 2'd2, 2'd1, 3'd2, 2'd1, 32'h22, 3'b000, 32'h22},
        '{1'b0, 2'd0, 2'd1, 3'd0, 2'd0, 32'h0,  3'b000, 32'h22},
        '{1'b1, 2'd1, 2'd2, 3'd0, 2'd0, 32'h0,  3'b000, 32'h0},
        '{1'b0, 2'd0, 2'd2, 3'd2, 2'd1, 32'h33, 3'b000, 32'h33},
        '{1'b1, 2'd2, 2'd1, 3'd0, 2'd0, 32'h0,  3'b011, 32'h22},
        '{1'b1, 2'd1, 2'd2, 3'd0, 2'd0, 32'h0,  3'b001, 32'h33},
        '{1'b0, 2'd1, 2'd2, 3'd0, 2'd0, 32'h0,  3'b000, 32'h33},
        '{1'b1, 2'd0, 2'd2, 3'd0, 2'd0, 32'h0,  3'b010, 32'h33},
        '{1'b0, 2'd2, 2'd2, 3'd2, 2'd0, 32'h44, 3'b000, 32'h44},
        '{1'b0, 2'd0, 2'd3, 3'd0, 2'd0, 32'h0,  3'b000, 32'h0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input vec_t v, input string reply_req);
        logic [2:0] got_inv = '0;
        int         last_inv = -1;
        bit         done = 0;
        bit         saw_pre = 0;
        int         rep_cyc = -1;
        int         exp_cyc;
        string      pre_req;
        pre_req = (v.pre_kind == 3'd3) ? "R4" : "R5";
        exp_cyc = (v.pre_kind != 0) ? 2 : $countones(v.inv_mask);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_src = v.src; req_addr = v.addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 12 && !done; c++) begin
            if (c > 0) @(negedge clk);
            wb_valid = 1'b0;
            if (msg_valid) begin
                chk(msg_local == (msg_dst == 2'd0), "R7", "local flag", 32'(msg_local),
                    32'(msg_dst == 2'd0));
                case (msg_kind)
                    3'd2, 3'd3: begin
                        saw_pre = 1;
                        chk(msg_kind == v.pre_kind && msg_dst == v.pre_dst, pre_req,
                            "fetch kind/dst", {27'd0, msg_kind, msg_dst},
                            {27'd0, v.pre_kind, v.pre_dst});
                        chk(msg_payload == 32'(v.addr) && !msg_has_data, "R8",
                            "fetch payload", msg_payload, 32'(v.addr));
                        wb_valid = 1'b1; wb_src = msg_dst; wb_addr = v.addr;
                        wb_data = v.wb_word;
                    end
                    3'd4: begin
                        chk(v.inv_mask[msg_dst] && !got_inv[msg_dst] && int'(msg_dst) > last_inv,
                            "R6", "invalidate target/order", 32'(msg_dst), 32'(v.inv_mask));
                        chk(msg_payload == 32'(v.addr) && !msg_has_data, "R8",
                            "invalidate payload", msg_payload, 32'(v.addr));
                        got_inv[msg_dst] = 1'b1;
                        last_inv = int'(msg_dst);
                    end
                    3'd5: begin
                        done = 1;
                        rep_cyc = c;
                        chk(msg_dst == v.src, reply_req, "reply dst", 32'(msg_dst), 32'(v.src));
                        chk(msg_payload == v.data && msg_has_data, "R8", "reply data",
                            msg_payload, v.data);
                        chk(!busy, "R9", "busy at reply", 32'(busy), 32'd0);
                    end
                    default: chk(0, "R9", "unexpected kind", 32'(msg_kind), 32'd5);
                endcase
            end
        end
        wb_valid = 1'b0;
        chk(done, reply_req, "reply seen", 32'(done), 32'd1);
        chk(rep_cyc == exp_cyc, "R9", "reply cycle", 32'(rep_cyc), 32'(exp_cyc));
        chk(got_inv == v.inv_mask, "R6", "invalidate set", 32'(got_inv), 32'(v.inv_mask));
        chk(saw_pre == (v.pre_kind != 0), "R11", "fetch presence", 32'(saw_pre),
            32'(v.pre_kind != 0));
    endtask

    task automatic expect_quiet(input int n, input string req, input bit exp_busy);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!msg_valid, req, "no message", 32'(msg_valid), 32'd0);
            chk(busy == exp_busy, req, "busy level", 32'(busy), 32'(exp_busy));
        end
    endtask

    bit finished = 0;

    initial begin
        #(4 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !msg_valid, "R1", "reset outputs", {30'd0, busy, msg_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (i == 0 || i == NV - 1) rq = "R1";
            else if (i == 8) rq = "R11";
            else if (VECS[i].wr && VECS[i].pre_kind == 0 && VECS[i].inv_mask == 0) rq = "R3";
            else if (VECS[i].wr && VECS[i].pre_kind == 0) rq = "R6";
            else if (VECS[i].pre_kind == 3'd3) rq = "R4";
            else if (VECS[i].pre_kind == 3'd2) rq = "R5";
            else rq = "R2";
            run_txn(VECS[i], rq);
        end

        // Directed: X (addr 1) is Exclusive at node 2; node 0 write-misses.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_src = 2'd0; req_addr = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(msg_valid && msg_kind == 3'd3 && msg_dst == 2'd2, "R4", "fetch-inv to owner",
            {27'd0, msg_kind, msg_dst}, {27'd0, 3'd3, 2'd2});
        chk(busy, "R9", "busy during fetch", 32'(busy), 32'd1);
        // R10 write-back from a non-owner, plus a request while busy (R9)
        wb_valid = 1'b1; wb_src = 2'd1; wb_addr = 2'd1; wb_data = 32'h55;
        req_valid = 1'b1; req_write = 1'b0; req_src = 2'd1; req_addr = 2'd2;
        @(negedge clk);
        wb_valid = 1'b0; req_valid = 1'b0;
        chk(!msg_valid && busy, "R10", "wrong-source write-back", 32'(msg_valid), 32'd0);
        expect_quiet(1, "R10", 1'b1);
        // R10 owner write-back at the wrong address
        wb_valid = 1'b1; wb_src = 2'd2; wb_addr = 2'd2; wb_data = 32'h56;
        @(negedge clk);
        wb_valid = 1'b0;
        chk(!msg_valid && busy, "R10", "wrong-address write-back", 32'(msg_valid), 32'd0);
        expect_quiet(1, "R10", 1'b1);
        // matching write-back
        wb_valid = 1'b1; wb_src = 2'd2; wb_addr = 2'd1; wb_data = 32'h66;
        @(negedge clk);
        wb_valid = 1'b0;
        chk(!msg_valid, "R4", "gap after write-back", 32'(msg_valid), 32'd0);
        @(negedge clk);
        chk(msg_valid && msg_kind == 3'd5 && msg_dst == 2'd0 && msg_payload == 32'h66,
            "R4", "reply after write-back", msg_payload, 32'h66);
        chk(msg_local, "R7", "home reply local", 32'(msg_local), 32'd1);
        // R9 the request dropped while busy must not appear
        expect_quiet(3, "R9", 1'b0);

        // node 1 read-misses X, now Exclusive at home node 0: local fetch
        run_txn('{1'b0, 2'd1, 2'd1, 3'd2, 2'd0, 32'h77, 3'b000, 32'h77}, "R5");
        // node 2 read-misses X (Shared {0,1}): direct reply with stored word
        run_txn('{1'b0, 2'd2, 2'd1, 3'd0, 2'd0, 32'h0, 3'b000, 32'h77}, "R2");
        // node 1 write-misses X: invalidates nodes 0 and 2
        run_txn('{1'b1, 2'd1, 2'd1, 3'd0, 2'd0, 32'h0, 3'b101, 32'h77}, "R6");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule